// File: doc/BRIEF.md
# Execute and Branch Resolution Stage

This block is the execute stage of a single-cycle RV32I processor. Within one cycle it takes the instruction word, the program counter, the two register read values, the decoded immediate and two operand-source selects from decode. From these it produces the ALU result, a jump request and the address the fetch stage should load when that request is raised.

The ALU operation is not an input to the block. It is decoded inside the block from the opcode, funct3 and funct7 of the instruction word. The first ALU operand is either the rs1 value or the PC. The second ALU operand is either the rs2 value or the immediate.

Conditional branches compare the two register values directly, independent of the operand selects. JAL and JALR always redirect fetch. The block is purely combinational and holds no state.

Top module: `exec_unit`

## Requirements
- R1: When `op1_from_pc` is 1, the first ALU operand is `pc`. When it is 0, the first ALU operand is `rs1_val`.
- R2: When `op2_from_imm` is 1, the second ALU operand is `imm`. When it is 0, the second ALU operand is `rs2_val`.
- R3: For opcode 0x33, funct3 selects the operation: 0 add, 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 logical right shift, 6 or, 7 and. Instruction bit 30 (funct7 bit 5) turns funct3 0 into subtract and funct3 5 into arithmetic right shift.
- R4: For opcode 0x13, the funct3 mapping of R3 applies, except that funct3 0 always adds whatever bit 30 holds. Bit 30 still selects arithmetic right shift for funct3 5.
- R5: Every shift uses only the low 5 bits of the second operand as its amount.
- R6: A less-than result is 1 or 0 in bit 0, with all upper bits zero.
- R7: For every opcode other than 0x33 and 0x13, the ALU adds its two selected operands.
- R8: For opcode 0x63, funct3 0 jumps exactly when `rs1_val` equals `rs2_val`, and funct3 1 jumps exactly when they differ.
- R9: For opcode 0x63, funct3 4 and 5 compare signed (less-than and greater-or-equal). Funct3 6 and 7 make the same comparisons unsigned. Funct3 2 and 3 never jump.
- R10: When a branch jumps, `jump_target` is `pc + imm`.
- R11: Opcode 0x6f always jumps, with target `pc + imm`.
- R12: Opcode 0x67 always jumps, with target `rs1_val + imm` and bit 0 forced to 0.
- R13: Whenever `jump_flag` is 0, including for every opcode other than 0x63, 0x6f and 0x67, `jump_target` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst | input | 32 | Instruction word being executed |
| pc | input | 32 | Address of the instruction |
| rs1_val | input | 32 | First register read value |
| rs2_val | input | 32 | Second register read value |
| imm | input | 32 | Sign-extended immediate from decode |
| op1_from_pc | input | 1 | Selects PC as first ALU operand |
| op2_from_imm | input | 1 | Selects immediate as second ALU operand |
| alu_result | output | 32 | ALU result |
| jump_flag | output | 1 | Fetch must load `jump_target` |
| jump_target | output | 32 | Redirect address, 0 when no jump |

## Verification
The ALU result and the branch decision come out in the same cycle from different sources. The ALU works on the muxed operands, while the branch comparison reads the raw register values. The bench provokes this overlap by driving branch, JAL and JALR words with random operand selects, so the ALU sum may or may not equal the redirect target. It also sets `rs2_val` equal to `rs1_val` half of the time, so the equality, signed and unsigned decisions all flip. A behavioural model recomputes all three outputs for every vector and compares each of them separately, so a decision taken from the wrong operand source shows up as a mismatch.

// File: rtl/exec_unit.sv
module exec_unit #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     inst,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm,
  input  logic            op1_from_pc,
  input  logic            op2_from_imm,
  output logic [XLEN-1:0] alu_result,
  output logic            jump_flag,
  output logic [XLEN-1:0] jump_target
);
  localparam int SHW = $clog2(XLEN);
  localparam logic [6:0] OPC_REG  = 7'h33;
  localparam logic [6:0] OPC_IMM  = 7'h13;
  localparam logic [6:0] OPC_BR   = 7'h63;
  localparam logic [6:0] OPC_JAL  = 7'h6f;
  localparam logic [6:0] OPC_JALR = 7'h67;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_SLL, FN_SLT, FN_SLTU, FN_XOR, FN_SRL, FN_SRA, FN_OR, FN_AND
  } alu_fn_t;

  logic [6:0] opcode;
  logic [2:0] f3;
  logic       alt;
  assign opcode = inst[6:0];
  assign f3     = inst[14:12];
  assign alt    = inst[30];

  alu_fn_t fn;
  always_comb begin
    fn = FN_ADD;
    if (opcode == OPC_REG || opcode == OPC_IMM) begin
      unique case (f3)
        3'd0: fn = (alt && opcode == OPC_REG) ? FN_SUB : FN_ADD;
        3'd1: fn = FN_SLL;
        3'd2: fn = FN_SLT;
        3'd3: fn = FN_SLTU;
        3'd4: fn = FN_XOR;
        3'd5: fn = alt ? FN_SRA : FN_SRL;
        3'd6: fn = FN_OR;
        default: fn = FN_AND;
      endcase
    end
  end

  logic [XLEN-1:0] opa, opb;
  logic [SHW-1:0]  shamt;
  assign opa   = op1_from_pc  ? pc  : rs1_val;
  assign opb   = op2_from_imm ? imm : rs2_val;
  assign shamt = opb[SHW-1:0];

  always_comb begin
    unique case (fn)
      FN_SUB:  alu_result = opa - opb;
      FN_SLL:  alu_result = opa << shamt;
      FN_SLT:  alu_result = {{(XLEN-1){1'b0}}, $signed(opa) < $signed(opb)};
      FN_SLTU: alu_result = {{(XLEN-1){1'b0}}, opa < opb};
      FN_XOR:  alu_result = opa ^ opb;
      FN_SRL:  alu_result = opa >> shamt;
      FN_SRA:  alu_result = XLEN'($signed(opa) >>> shamt);
      FN_OR:   alu_result = opa | opb;
      FN_AND:  alu_result = opa & opb;
      default: alu_result = opa + opb;
    endcase
  end

  logic taken;
  always_comb begin
    unique case (f3)
      3'd0: taken = rs1_val == rs2_val;
      3'd1: taken = rs1_val != rs2_val;
      3'd4: taken = $signed(rs1_val) <  $signed(rs2_val);
      3'd5: taken = $signed(rs1_val) >= $signed(rs2_val);
      3'd6: taken = rs1_val <  rs2_val;
      3'd7: taken = rs1_val >= rs2_val;
      default: taken = 1'b0;
    endcase
  end

  logic [XLEN-1:0] pc_rel, reg_rel;
  assign pc_rel  = pc + imm;
  assign reg_rel = rs1_val + imm;

  always_comb begin
    jump_flag   = 1'b0;
    jump_target = '0;
    if (opcode == OPC_JAL) begin
      jump_flag   = 1'b1;
      jump_target = pc_rel;
    end else if (opcode == OPC_JALR) begin
      jump_flag   = 1'b1;
      jump_target = {reg_rel[XLEN-1:1], 1'b0};
    end else if (opcode == OPC_BR && taken) begin
      jump_flag   = 1'b1;
      jump_target = pc_rel;
    end
  end

  always_comb begin
    a_r13_idle_target: assert (jump_flag || jump_target == '0);
    if (opcode == OPC_JALR) begin
      a_r12_even_target: assert (jump_flag && !jump_target[0]);
    end
    if (opcode == OPC_JAL) begin
      a_r11_always_jumps: assert (jump_flag);
    end
    if (opcode == OPC_BR && f3 == 3'd0 && rs1_val == rs2_val) begin
      a_r8_beq_equal: assert (jump_flag && jump_target == pc + imm);
    end
    if (opcode == OPC_BR && (f3 == 3'd2 || f3 == 3'd3)) begin
      a_r9_reserved_never: assert (!jump_flag);
    end
    if (fn == FN_SLT || fn == FN_SLTU) begin
      a_r6_compare_width: assert (alu_result[XLEN-1:1] == '0);
    end
  end
endmodule

// File: tb/test_exec_unit.sv
module test_exec_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] inst, pc, rs1_val, rs2_val, imm;
  logic        op1_from_pc, op2_from_imm;
  logic [31:0] alu_result, jump_target;
  logic        jump_flag;

  exec_unit i_exec_unit (
    .inst(inst), .pc(pc), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm),
    .op1_from_pc(op1_from_pc), .op2_from_imm(op2_from_imm),
    .alu_result(alu_result), .jump_flag(jump_flag), .jump_target(jump_target)
  );

  int n_checks = 0;
  int n_fail   = 0;

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] opc);
    return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
  endfunction

  logic [31:0] e_alu, e_tgt;
  logic        e_jmp;

  task automatic model();
    logic [31:0] a, b;
    int sh;
    logic [6:0] opc;
    logic [2:0] f3;
    logic t;
    opc = inst[6:0];
    f3  = inst[14:12];
    a   = op1_from_pc ? pc : rs1_val;
    b   = op2_from_imm ? imm : rs2_val;
    sh  = int'(b % 32);
    e_alu = a + b;
    if (opc == 7'h33 || opc == 7'h13) begin
      case (f3)
        3'd0: if (opc == 7'h33 && inst[30]) e_alu = a - b;
        3'd1: e_alu = a << sh;
        3'd2: e_alu = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        3'd3: e_alu = (a < b) ? 32'd1 : 32'd0;
        3'd4: e_alu = a ^ b;
        3'd5: e_alu = inst[30] ? 32'($signed(a) >>> sh) : a >> sh;
        3'd6: e_alu = a | b;
        default: e_alu = a & b;
      endcase
    end
    e_jmp = 1'b0;
    e_tgt = 32'd0;
    if (opc == 7'h6f) begin
      e_jmp = 1'b1;
      e_tgt = pc + imm;
    end else if (opc == 7'h67) begin
      e_jmp = 1'b1;
      e_tgt = (rs1_val + imm) & 32'hffff_fffe;
    end else if (opc == 7'h63) begin
      case (f3)
        3'd0: t = rs1_val == rs2_val;
        3'd1: t = rs1_val != rs2_val;
        3'd4: t = $signed(rs1_val) < $signed(rs2_val);
        3'd5: t = !($signed(rs1_val) < $signed(rs2_val));
        3'd6: t = rs1_val < rs2_val;
        3'd7: t = !(rs1_val < rs2_val);
        default: t = 1'b0;
      endcase
      if (t) begin
        e_jmp = 1'b1;
        e_tgt = pc + imm;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (inst %h)", tag, what, act, exp, inst);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] i, input logic [31:0] p, input logic [31:0] r1,
                     input logic [31:0] r2, input logic [31:0] im, input logic s1, input logic s2);
    @(posedge clk);
    inst = i; pc = p; rs1_val = r1; rs2_val = r2; imm = im;
    op1_from_pc = s1; op2_from_imm = s2;
    @(negedge clk);
    model();
    chk(tag, "alu_result", alu_result, e_alu);
    chk(tag, "jump_flag", {31'd0, jump_flag}, {31'd0, e_jmp});
    chk(tag, "jump_target", jump_target, e_tgt);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [6:0] opcs [9];
    opcs = '{7'h33, 7'h13, 7'h63, 7'h6f, 7'h67, 7'h03, 7'h23, 7'h37, 7'h17};
    inst = 0; pc = 0; rs1_val = 0; rs2_val = 0; imm = 0; op1_from_pc = 0; op2_from_imm = 0;
    // R13 idle: all-zero inputs give zero outputs
    run("R13", 32'd0, 0, 0, 0, 0, 0, 0);
    // R1 and R2 operand selects, R7 add for load opcode
    run("R1", mk(0, 0, 7'h03), 32'h1000, 32'h10, 32'h20, 32'h4, 1, 0);
    run("R2", mk(0, 0, 7'h03), 32'h1000, 32'h10, 32'h20, 32'h4, 0, 1);
    run("R7", mk(0, 2, 7'h23), 32'h1000, 32'h10, 32'h20, 32'h4, 1, 1);
    // R3 subtract and arithmetic shift
    run("R3", mk(7'h20, 0, 7'h33), 0, 32'd5, 32'd7, 0, 0, 0);
    run("R3", mk(7'h20, 5, 7'h33), 0, 32'h8000_0000, 32'd4, 0, 0, 0);
    // R4 immediate add ignores bit 30, SRAI honours it
    run("R4", mk(7'h20, 0, 7'h13), 0, 32'd5, 0, 32'd7, 0, 1);
    run("R4", mk(7'h20, 5, 7'h13), 0, 32'hf000_0000, 0, 32'd8, 0, 1);
    // R5 shift amount uses low 5 bits only
    run("R5", mk(0, 1, 7'h33), 0, 32'd1, 32'h0000_0021, 0, 0, 0);
    // R6 signed vs unsigned less-than
    run("R6", mk(0, 2, 7'h33), 0, 32'hffff_ffff, 32'd1, 0, 0, 0);
    run("R6", mk(0, 3, 7'h33), 0, 32'hffff_ffff, 32'd1, 0, 0, 0);
    // R8 BEQ taken and not taken, BNE
    run("R8", mk(0, 0, 7'h63), 32'h1000, 32'd9, 32'd9, 32'h4, 0, 0);
    run("R8", mk(0, 0, 7'h63), 32'h1000, 32'd9, 32'd8, 32'h4, 0, 0);
    run("R8", mk(0, 1, 7'h63), 32'h1000, 32'd9, 32'd8, 32'hffff_fff0, 0, 0);
    // R9 signed/unsigned split and reserved funct3
    run("R9", mk(0, 4, 7'h63), 32'h2000, 32'hffff_ffff, 32'd1, 32'h8, 0, 0);
    run("R9", mk(0, 6, 7'h63), 32'h2000, 32'hffff_ffff, 32'd1, 32'h8, 0, 0);
    run("R9", mk(0, 7, 7'h63), 32'h2000, 32'hffff_ffff, 32'd1, 32'h8, 0, 0);
    run("R9", mk(0, 2, 7'h63), 32'h2000, 32'd1, 32'd1, 32'h8, 0, 0);
    // R10 taken branch target, R11 JAL, R12 JALR odd sum
    run("R10", mk(0, 5, 7'h63), 32'h3000, 32'd3, 32'd3, 32'hffff_fffc, 1, 1);
    run("R11", mk(0, 0, 7'h6f), 32'h3000, 32'd3, 32'd3, 32'h100, 1, 0);
    run("R12", mk(0, 0, 7'h67), 32'h3000, 32'h401, 32'd3, 32'h10, 0, 1);
    // random vectors across all classes
    for (int k = 0; k < 3000; k++) begin
      logic [6:0] opc;
      logic [31:0] r1, r2;
      string tag;
      opc = opcs[$urandom_range(0, 8)];
      r1  = $urandom;
      r2  = ($urandom_range(0, 1) == 1) ? r1 : $urandom;
      case (opc)
        7'h33: tag = "R3";
        7'h13: tag = "R4";
        7'h63: tag = "R9";
        7'h6f: tag = "R11";
        7'h67: tag = "R12";
        default: tag = "R7";
      endcase
      run(tag, {$urandom_range(0, 1) == 1 ? 7'h20 : 7'($urandom), 18'($urandom), 7'h00} | {25'd0, opc},
          $urandom, r1, r2, $urandom, 1'($urandom), 1'($urandom));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule